// File: doc/BRIEF.md
# Multi-Format Audio Serial Transmitter

This block turns a stream of audio sample words into one serial data line and the matching frame-sync line. A separate clock generator supplies the timing. It provides a one-cycle bit-clock enable (`bit_tick`) and, optionally, a frame marker (`frame_mark`) that puts the bit position back to the start of a frame. Each channel slot is 32 bit periods long. The block supports three two-channel framings: I2S, left-justified and right-justified. It also supports two short-pulse DSP framings, in which 2, 4, 6 or 8 slots run back to back on the single line.

Samples arrive over a ready/valid pop interface. One word is taken at the first bit of each slot. Left (even) slots come first. A slot with no word available is sent as zeros. The sample width is programmed as bits minus one. Bits beyond that width are sent as zero. When `tx_run` is cleared, the outputs fall silent and no words are taken. When it is set again, transmission restarts at the next frame start.

Top module: `aud_ser_tx`

## Requirements
- R1: The framing is decoded from the mode pins as follows.
  - With `fmt_dsp`=0, `fmt_std` selects the framing: 0 is I2S, 1 is left-justified, 2 is right-justified, and 3 behaves as I2S.
  - With `fmt_dsp`=1, `dsp_pulse`=0 selects DSP-A and any other value selects DSP-B.
- R2: In I2S framing, `ws_out` is 0 for the left slot (frame positions 0..31) and 1 for the right slot (positions 32..63). The word MSB is sent at slot position 1. Slot position 0 carries bit 31 of the previous slot's 32-bit stream, which is that word's LSB only when the width is 32 and is 0 otherwise.
- R3: In left-justified framing, `ws_out` is 1 for the left slot and 0 for the right slot. The MSB is sent at slot position 0.
- R4: In right-justified framing, `ws_out` is 1 for the left slot. The LSB is sent at slot position 31, and the positions ahead of the word are 0.
- R5: In DSP-A framing, the frame holds 2×(`pairs_m1`+1) slots of 32 bits. `ws_out` is a one-bit pulse at frame position 0. Each slot's MSB is sent one bit after the slot start, with the same one-bit delay as I2S.
- R6: In DSP-B framing, the frame and the pulse are the same as in DSP-A, but each slot's MSB is sent at the slot start.
- R7: The sample width is `wl_m1`+1 bits, with bit `wl_m1` as the MSB. Every slot position that is not occupied by the word is sent as 0.
- R8: In the I2S, left-justified and right-justified framings the frame is always 64 bit periods long, and `pairs_m1` has no effect.
- R9: `smp_ready` is high only in the cycle with `bit_tick` at a slot start while transmitting. A word is taken when `smp_valid` is also high. A slot without a word is sent as all zeros.
- R10: While `tx_run` is 0, no word is taken, and `sd_out` and `ws_out` are 0 from the next bit tick onward. After `tx_run` rises, transmission begins at the next frame position 0, with the left slot first.
- R11: `frame_mark` together with `bit_tick` makes that bit frame position 0. Without a mark, the position wraps after the last bit of the frame.
- R12: `sd_out` and `ws_out` are registered. They change only at a clock edge where `bit_tick` is high, and they reset to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bit_tick | input | 1 | One-cycle enable per serial bit period |
| frame_mark | input | 1 | With bit_tick, forces frame position 0 |
| tx_run | input | 1 | Transmit enable |
| fmt_dsp | input | 1 | 1 selects the DSP pulse framings |
| fmt_std | input | 2 | 0 I2S, 1 left-justified, 2 right-justified |
| dsp_pulse | input | 2 | 0 DSP-A, otherwise DSP-B |
| wl_m1 | input | 5 | Sample width minus one |
| pairs_m1 | input | 2 | Channel pairs minus one (DSP framings) |
| smp_data | input | 32 | Sample word |
| smp_valid | input | 1 | Sample word available |
| smp_ready | output | 1 | Word taken at this cycle when valid |
| sd_out | output | 1 | Serial data bit |
| ws_out | output | 1 | Word select or frame pulse |

## Verification
The assertions assume two things about the inputs. First, the mode, width and pair-count pins change only while `tx_run` is low. Second, `frame_mark` is never high on two consecutive bit ticks, so a DSP pulse always falls back after one bit. The stimulus follows both rules: every configuration change is made inside a quiet gap with `tx_run` low, and the frame mark is forced on a single tick in the middle of a frame. The bench runs with bit ticks every second cycle and every fifth cycle. It starves the sample stream and restarts transmission in the middle of a frame, so the frame-start rule is exercised.

// File: rtl/aud_ser_pkg.sv
`timescale 1ns/1ps
// Shared types for the audio serial transmitter.
// Assumes: the mode fields are decoded once, at the top level.
package aud_ser_pkg;

    typedef enum logic [2:0] {
        FR_I2S  = 3'd0,
        FR_LJ   = 3'd1,
        FR_RJ   = 3'd2,
        FR_DSPA = 3'd3,
        FR_DSPB = 3'd4
    } frame_mode_e;

    // Decode the three mode fields into a single framing.
    function automatic frame_mode_e pick_mode(input logic dsp_sel,
                                              input logic [1:0] std_sel,
                                              input logic [1:0] pulse_sel);
        frame_mode_e m;
        if (dsp_sel) begin
            m = (pulse_sel == 2'd0) ? FR_DSPA : FR_DSPB;
        end else begin
            case (std_sel)
                2'd1:    m = FR_LJ;
                2'd2:    m = FR_RJ;
                default: m = FR_I2S;
            endcase
        end
        return m;
    endfunction

    // Framings in which the MSB trails the slot start by one bit.
    function automatic logic is_delayed(input frame_mode_e m);
        return (m == FR_I2S) || (m == FR_DSPA);
    endfunction

endpackage

// File: rtl/aud_ser_pos.sv
`timescale 1ns/1ps
// Bit-position counter within the frame.
// Purpose: tracks which bit of the frame is sent next and wraps at the frame length.
// Assumes: is_dsp and pairs_m1 are stable while transmitting. frame_mark is only
// looked at on a bit tick.
module aud_ser_pos #(
    parameter int SLOT_W    = 32,
    parameter int MAX_PAIRS = 4,
    localparam int SB       = $clog2(SLOT_W),
    localparam int PAIR_W   = (MAX_PAIRS > 1) ? $clog2(MAX_PAIRS) : 1,
    localparam int POS_W    = $clog2(2 * SLOT_W * MAX_PAIRS),
    localparam int LEN_W    = POS_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_tick,
    input  logic              frame_mark,
    input  logic              is_dsp,
    input  logic [PAIR_W-1:0] pairs_m1,
    output logic [POS_W-1:0]  pos_next,
    output logic [POS_W-1:0]  pos_q
);

    logic [LEN_W-1:0] frame_len;
    logic [LEN_W-1:0] last_pos;

    // Frame length: two slots per pair in the DSP framings, otherwise always two slots.
    always_comb begin
        if (is_dsp) begin
            frame_len = (LEN_W'(pairs_m1) + LEN_W'(1)) << (SB + 1);
        end else begin
            frame_len = LEN_W'(2 * SLOT_W);
        end
        last_pos = frame_len - LEN_W'(1);
    end

    // Next position: hold between ticks, restart on a mark or at the frame end.
    always_comb begin
        if (!bit_tick) begin
            pos_next = pos_q;
        end else if (frame_mark) begin
            pos_next = '0;
        end else if ({1'b0, pos_q} >= last_pos) begin
            pos_next = '0;
        end else begin
            pos_next = pos_q + POS_W'(1);
        end
    end

    // Position register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos_q <= '0;
        end else begin
            pos_q <= pos_next;
        end
    end

    p_mark_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_tick && frame_mark) |=> (pos_q == '0))
        else $error("frame mark did not restart the position");

    p_pos_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_tick |=> $stable(pos_q))
        else $error("position moved without a bit tick");

endmodule

// File: rtl/aud_ser_word.sv
`timescale 1ns/1ps
// Slot word capture.
// Purpose: takes one sample per slot start and holds it for the rest of the slot.
// Assumes: go is high only while transmitting. slot_start is valid on bit ticks.
module aud_ser_word #(
    parameter int SLOT_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_tick,
    input  logic              go,
    input  logic              slot_start,
    input  logic [SLOT_W-1:0] smp_data,
    input  logic              smp_valid,
    output logic              smp_ready,
    output logic [SLOT_W-1:0] word_next,
    output logic [SLOT_W-1:0] word_q
);

    // Pop strobe: only at a slot start, on a tick, while transmitting.
    always_comb smp_ready = bit_tick && go && slot_start;

    // Word for the bit being entered: a new sample, zero fill, or the held word.
    always_comb begin
        if (!go) begin
            word_next = '0;
        end else if (slot_start) begin
            word_next = smp_valid ? smp_data : '0;
        end else begin
            word_next = word_q;
        end
    end

    // Held word register, updated once per bit tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q <= '0;
        end else if (bit_tick) begin
            word_q <= word_next;
        end
    end

    p_empty_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_ready && !smp_valid) |=> (word_q == '0))
        else $error("starved slot did not load zeros");

endmodule

// File: rtl/aud_ser_shape.sv
`timescale 1ns/1ps
// Serial bit and frame-sync shaper.
// Purpose: picks the data bit for the current slot position under the selected
// framing, builds the word-select or pulse level, and registers both on a bit tick.
// Assumes: word_q still holds the previous slot's word when a slot starts.
module aud_ser_shape
    import aud_ser_pkg::*;
#(
    parameter int SLOT_W = 32,
    localparam int SB    = $clog2(SLOT_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_tick,
    input  logic              go,
    input  frame_mode_e       mode,
    input  logic [SB-1:0]     wl_m1,
    input  logic [SB-1:0]     bit_idx,
    input  logic              chan_odd,
    input  logic              frame_start,
    input  logic [SLOT_W-1:0] word_next,
    input  logic [SLOT_W-1:0] word_q,
    output logic              sd_out,
    output logic              ws_out
);

    logic          tail_bit;
    logic [SB-1:0] k_idx;
    logic          lj_bit;
    logic [SB-1:0] rj_thr;
    logic          rj_bit;
    logic          sd_d;
    logic          ws_d;
    logic          dsp_mode;

    // Data bit selection for the justified and delayed framings.
    always_comb begin
        tail_bit = (wl_m1 == SB'(SLOT_W - 1)) ? word_q[0] : 1'b0;
        k_idx    = bit_idx - SB'(is_delayed(mode));
        lj_bit   = (k_idx <= wl_m1) ? word_next[wl_m1 - k_idx] : 1'b0;
        rj_thr   = SB'(SLOT_W - 1) - wl_m1;
        rj_bit   = (bit_idx >= rj_thr) ? word_next[SB'(SLOT_W - 1) - bit_idx] : 1'b0;
        case (mode)
            FR_RJ:           sd_d = rj_bit;
            FR_I2S, FR_DSPA: sd_d = (bit_idx == '0) ? tail_bit : lj_bit;
            default:         sd_d = lj_bit;
        endcase
    end

    // Word-select level or one-bit frame pulse.
    always_comb begin
        dsp_mode = (mode == FR_DSPA) || (mode == FR_DSPB);
        case (mode)
            FR_I2S:       ws_d = chan_odd;
            FR_LJ, FR_RJ: ws_d = !chan_odd;
            default:      ws_d = frame_start;
        endcase
    end

    // Output registers, silenced while not transmitting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sd_out <= 1'b0;
            ws_out <= 1'b0;
        end else if (bit_tick) begin
            sd_out <= go && sd_d;
            ws_out <= go && ws_d;
        end
    end

    p_idle_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_tick && !go) |=> (!sd_out && !ws_out))
        else $error("outputs active while stopped");

    p_out_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_tick |=> ($stable(sd_out) && $stable(ws_out)))
        else $error("outputs moved without a bit tick");

    p_dsp_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_tick && go && dsp_mode && !frame_start) |=> !ws_out)
        else $error("frame pulse longer than one bit");

endmodule

// File: rtl/aud_ser_tx.sv
`timescale 1ns/1ps
// Multi-format audio serial transmitter, top level.
// Purpose: decodes the framing, gates transmission to frame starts, and joins the
// position counter, the slot word capture and the bit shaper.
// Assumes: configuration pins change only while tx_run is low. The slot width
// equals the sample word width.
module aud_ser_tx
    import aud_ser_pkg::*;
#(
    parameter int SLOT_W    = 32,
    parameter int MAX_PAIRS = 4,
    localparam int SB       = $clog2(SLOT_W),
    localparam int PAIR_W   = (MAX_PAIRS > 1) ? $clog2(MAX_PAIRS) : 1,
    localparam int POS_W    = $clog2(2 * SLOT_W * MAX_PAIRS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_tick,
    input  logic              frame_mark,
    input  logic              tx_run,
    input  logic              fmt_dsp,
    input  logic [1:0]        fmt_std,
    input  logic [1:0]        dsp_pulse,
    input  logic [SB-1:0]     wl_m1,
    input  logic [PAIR_W-1:0] pairs_m1,
    input  logic [SLOT_W-1:0] smp_data,
    input  logic              smp_valid,
    output logic              smp_ready,
    output logic              sd_out,
    output logic              ws_out
);

    frame_mode_e       mode;
    logic [POS_W-1:0]  pos_next;
    logic [POS_W-1:0]  pos_q;
    logic              act_q;
    logic              frame_start;
    logic              slot_start;
    logic              go;
    logic [SLOT_W-1:0] word_next;
    logic [SLOT_W-1:0] word_q;

    // Framing decode and position flags.
    always_comb begin
        mode        = pick_mode(fmt_dsp, fmt_std, dsp_pulse);
        frame_start = (pos_next == '0);
        slot_start  = (pos_next[SB-1:0] == '0);
        go          = tx_run && (act_q || frame_start);
    end

    // Active flag: set at a frame start while running, cleared at once when stopped.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q <= 1'b0;
        end else if (!tx_run) begin
            act_q <= 1'b0;
        end else if (bit_tick && frame_start) begin
            act_q <= 1'b1;
        end
    end

    aud_ser_pos #(.SLOT_W(SLOT_W), .MAX_PAIRS(MAX_PAIRS)) u_pos (
        .clk        (clk),
        .rst_n      (rst_n),
        .bit_tick   (bit_tick),
        .frame_mark (frame_mark),
        .is_dsp     (fmt_dsp),
        .pairs_m1   (pairs_m1),
        .pos_next   (pos_next),
        .pos_q      (pos_q)
    );

    aud_ser_word #(.SLOT_W(SLOT_W)) u_word (
        .clk        (clk),
        .rst_n      (rst_n),
        .bit_tick   (bit_tick),
        .go         (go),
        .slot_start (slot_start),
        .smp_data   (smp_data),
        .smp_valid  (smp_valid),
        .smp_ready  (smp_ready),
        .word_next  (word_next),
        .word_q     (word_q)
    );

    aud_ser_shape #(.SLOT_W(SLOT_W)) u_shape (
        .clk         (clk),
        .rst_n       (rst_n),
        .bit_tick    (bit_tick),
        .go          (go),
        .mode        (mode),
        .wl_m1       (wl_m1),
        .bit_idx     (pos_next[SB-1:0]),
        .chan_odd    (pos_next[SB]),
        .frame_start (frame_start),
        .word_next   (word_next),
        .word_q      (word_q),
        .sd_out      (sd_out),
        .ws_out      (ws_out)
    );

    p_ready_run_r9: assert property (@(posedge clk) disable iff (!rst_n)
        smp_ready |-> (tx_run && bit_tick))
        else $error("pop outside a running tick");

    p_start_frame_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(act_q) |-> (pos_q == '0))
        else $error("transmission began away from a frame start");

endmodule

// File: tb/sim_aud_ser_tx.sv
`timescale 1ns/1ps
// Bench: a behavioural reference model stepped every clock and compared with the outputs.
module sim_aud_ser_tx;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bit_tick = 1'b0;
    logic        frame_mark = 1'b0;
    logic        tx_run = 1'b0;
    logic        fmt_dsp = 1'b0;
    logic [1:0]  fmt_std = 2'd0;
    logic [1:0]  dsp_pulse = 2'd0;
    logic [4:0]  wl_m1 = 5'd15;
    logic [1:0]  pairs_m1 = 2'd0;
    logic [31:0] smp_data = '0;
    logic        smp_valid = 1'b0;
    logic        smp_ready;
    logic        sd_out;
    logic        ws_out;

    always #2.5 clk = ~clk;

    aud_ser_tx u0 (
        .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .frame_mark(frame_mark),
        .tx_run(tx_run), .fmt_dsp(fmt_dsp), .fmt_std(fmt_std), .dsp_pulse(dsp_pulse),
        .wl_m1(wl_m1), .pairs_m1(pairs_m1), .smp_data(smp_data), .smp_valid(smp_valid),
        .smp_ready(smp_ready), .sd_out(sd_out), .ws_out(ws_out)
    );

    int          checks = 0;
    int          errors = 0;
    bit          done = 1'b0;
    string       tag = "R12";
    // configuration and stimulus knobs
    bit          c_dsp = 0;
    int          c_std = 0, c_pulse = 0, c_wl = 15, c_pairs = 0;
    int          tdiv = 2;
    int          cyc = 0;
    bit          run_r = 0;
    bit          allow = 1;
    bit          force_mark = 0;
    // reference model state
    int          mpos = 0;
    bit          mact = 0;
    logic [31:0] mword = '0;
    bit          esd = 0, ews = 0, erdy = 0;
    logic [31:0] q[$];

    task automatic chk(input bit ok, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic fill(input int n);
        for (int i = 0; i < n; i++) q.push_back($urandom);
    endtask

    // One clock: compare outputs, drive inputs, step the model, compare the pop strobe.
    task automatic one_cycle();
        int len, npos, p, slot, w, k, mode;
        bit go, tk, fm, dly, popv;
        logic [31:0] old;
        @(negedge clk);
        chk(sd_out === esd, "sd_out", int'(sd_out), int'(esd));
        chk(ws_out === ews, "ws_out", int'(ws_out), int'(ews));
        tk = (cyc % tdiv) == 0;
        cyc++;
        fm = tk && force_mark;
        if (fm) force_mark = 0;
        bit_tick   = tk;
        frame_mark = fm;
        tx_run     = run_r;
        fmt_dsp    = c_dsp;
        fmt_std    = 2'(c_std);
        dsp_pulse  = 2'(c_pulse);
        wl_m1      = 5'(c_wl);
        pairs_m1   = 2'(c_pairs);
        popv       = allow && (q.size() > 0);
        smp_valid  = popv;
        smp_data   = (q.size() > 0) ? q[0] : 32'd0;
        #1;
        // R1: mode decode
        if (c_dsp) mode = (c_pulse == 0) ? 3 : 4;
        else mode = (c_std == 1) ? 1 : (c_std == 2) ? 2 : 0;
        erdy = 0;
        if (tk) begin
            len  = c_dsp ? 64 * (c_pairs + 1) : 64;   // R5, R8
            npos = fm ? 0 : ((mpos >= len - 1) ? 0 : mpos + 1);  // R11
            go   = run_r && (mact || npos == 0);      // R10
            p    = npos % 32;
            slot = npos / 32;
            old  = mword;
            if (!go) mword = '0;
            else if (p == 0) begin
                erdy = 1;                              // R9
                if (popv) mword = q.pop_front(); else mword = '0;
            end
            w = c_wl + 1;                              // R7
            if (!go) begin
                esd = 0; ews = 0;
            end else begin
                if (mode == 2) begin                   // R4
                    k = p - (32 - w);
                    esd = (k >= 0) ? mword[w - 1 - k] : 1'b0;
                end else begin                         // R2 R3 R5 R6
                    dly = (mode == 0) || (mode == 3);
                    k = p - int'(dly);
                    if (k < 0) esd = (w == 32) ? old[0] : 1'b0;
                    else esd = (k < w) ? mword[w - 1 - k] : 1'b0;
                end
                if (mode == 0) ews = slot[0];
                else if (mode <= 2) ews = !slot[0];
                else ews = (npos == 0);
            end
            mpos = npos;
            if (!run_r) mact = 0; else if (npos == 0) mact = 1;
        end else begin
            if (!run_r) mact = 0;
        end
        chk(smp_ready === erdy, "smp_ready", int'(smp_ready), int'(erdy));
    endtask

    task automatic phase(input string t, input bit dsp, input int std, input int pulse,
                         input int wl, input int pairs, input int cycles);
        tag = t;
        run_r = 0;
        repeat (8) one_cycle();
        c_dsp = dsp; c_std = std; c_pulse = pulse; c_wl = wl; c_pairs = pairs;
        fill(cycles / 40 + 4);
        run_r = 1;
        repeat (cycles) one_cycle();
    endtask

    initial begin
        rst_n = 0;
        repeat (4) @(negedge clk);
        tag = "R12";   // reset state
        chk(sd_out === 1'b0, "reset sd_out", int'(sd_out), 0);
        chk(ws_out === 1'b0, "reset ws_out", int'(ws_out), 0);
        chk(smp_ready === 1'b0, "reset smp_ready", int'(smp_ready), 0);
        rst_n = 1;
        q.push_back(32'h8000_0001);
        q.push_back(32'hFFFF_0000);
        phase("R1 R2 i2s", 0, 0, 0, 15, 0, 700);
        phase("R3 lj", 0, 1, 0, 23, 0, 600);
        phase("R4 rj", 0, 2, 0, 15, 0, 600);
        phase("R4 R7 rj narrow", 0, 2, 0, 7, 0, 400);
        phase("R5 dspa", 1, 0, 0, 31, 1, 1200);
        phase("R6 R1 dspb", 1, 0, 2, 19, 0, 600);
        phase("R7 i2s full width", 0, 0, 0, 31, 0, 600);
        phase("R8 lj pairs ignored", 0, 1, 0, 15, 3, 600);
        phase("R1 std3", 0, 3, 0, 11, 0, 400);
        // R9: starved stream
        phase("R9 starve", 0, 1, 0, 15, 0, 200);
        allow = 0; repeat (300) one_cycle();
        allow = 1; repeat (300) one_cycle();
        // R10: stop and restart mid-frame
        phase("R10 restart", 1, 0, 1, 15, 1, 300);
        run_r = 0; repeat (37) one_cycle();
        run_r = 1; repeat (500) one_cycle();
        // R11: early frame mark
        phase("R11 mark", 0, 0, 0, 15, 0, 150);
        force_mark = 1; repeat (400) one_cycle();
        // R12: sparse ticks
        tdiv = 5;
        phase("R12 sparse", 1, 0, 0, 23, 2, 2000);
        run_r = 0; repeat (20) one_cycle();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog %s actual=running expected=finished", tag);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule